// File: doc/BRIEF.md
# USB Bus Event Flag Register

This block holds the four bus-level event flags of a USB device controller in one byte that the CPU can read: start of frame, bus reset, resume and suspend. Each flag is set from a one-cycle strobe that the serial interface engine sends. The resume flag is accepted only while the device is in the suspended state. The suspend flag is accepted only while suspend detection is enabled. A CPU read of the register returns the pending flags and clears all of them at the same clock edge. An event that arrives in the same cycle as that read still survives the clear.

The start-of-frame flag is also driven by a frame timer. The timer starts on the first real frame token after reset. It then produces a synthetic frame event whenever a token is overdue by more than a small tolerance, so the frame flag keeps its 1 ms rhythm even when a token is lost or corrupted. A token that arrives late, just after a synthetic event, realigns the timer without raising a second event for that frame.

The interrupt request output is high while any flag is pending.

Top module: `usb_evt_flags`

## Requirements
- R1: The read data places the flags at fixed bit positions: bit 3 is start of frame, bit 2 is bus reset, bit 1 is resume and bit 0 is suspend. Bits 7 to 4 are always 0. The read data is all zero unless `rdStb` is 1 and `rdAddr` equals 0x06.
- R2: After reset all flags are 0 and `irq` is 0.
- R3: A read at address 0x06 returns the flag values held before the read, and all flags are 0 after the next clock edge. A read at any other address clears nothing.
- R4: An event strobe that arrives in the same cycle as a clearing read leaves its flag set after that edge.
- R5: A `busRst` strobe sets bit 2.
- R6: A `resumeDet` strobe sets bit 1 only while `suspended` is 1. While `suspended` is 0 it has no effect.
- R7: A `suspendDet` strobe sets bit 0 only while `suspEn` is 1. While `suspEn` is 0 it has no effect.
- R8: A `sofTok` strobe sets bit 3 at the edge where it is sampled, unless R11 suppresses it.
- R9: Once the timer is running, if no token arrives, a synthetic event sets bit 3 exactly FRAME_TICKS+TOL_TICKS cycles after the edge that sampled the last token. Further synthetic events follow every FRAME_TICKS cycles.
- R10: Between reset and the first `sofTok`, the frame timer produces no synthetic events.
- R11: A `sofTok` that arrives within TOL_TICKS cycles after a synthetic event does not set bit 3. It restarts the timer, so the next synthetic event comes FRAME_TICKS+TOL_TICKS cycles after that token.
- R12: `irq` is 1 exactly while at least one flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sofTok | input | 1 | Valid frame token received (one-cycle strobe) |
| busRst | input | 1 | Reset signaling detected on the bus (strobe) |
| resumeDet | input | 1 | Resume signaling detected (strobe) |
| suspendDet | input | 1 | Suspend signaling detected (strobe) |
| suspEn | input | 1 | Suspend detection enable |
| suspended | input | 1 | Device is currently suspended |
| rdStb | input | 1 | CPU register read strobe |
| rdAddr | input | 8 | CPU register address |
| rdData | output | 8 | Read data; flags in bits 3..0 |
| irq | output | 1 | Interrupt request, high while any flag is pending |

## Verification
If a flag register is stuck or holds a wrong value, `irq` shows it on the cycle after the faulty edge, and the next read at address 0x06 shows which bit is wrong. If the frame counter is wrong, the synthetic flag rises early or late. Sampling `irq` on the single cycle before and after the expected edge exposes an off-by-one within one frame. The timing of the next synthetic event after a resync shows whether the reload value was wrong. A broken late-token guard shows up as a flag that is set when the following read expects zero.

// File: rtl/usb_evt_pkg.sv
package usb_evt_pkg;
  localparam int FLAG_W  = 4;
  localparam int SUS_BIT = 0;
  localparam int RSU_BIT = 1;
  localparam int RST_BIT = 2;
  localparam int SOF_BIT = 3;

  typedef struct packed {
    logic setSof;
    logic setRst;
    logic setRsu;
    logic setSus;
    logic clrAll;
  } evtStrb_t;
endpackage

// File: rtl/usb_frame_timer.sv
module usb_frame_timer #(
  parameter int FRAME_TICKS = 12000,
  parameter int TOL_TICKS   = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic sofTok,
  output logic sofEvt
);
  localparam int CNT_W = $clog2(FRAME_TICKS + 2 * TOL_TICKS + 1);
  localparam logic [CNT_W-1:0] LIMIT_C = CNT_W'(FRAME_TICKS + TOL_TICKS - 1);
  localparam logic [CNT_W-1:0] RELOAD_C = CNT_W'(TOL_TICKS);
  localparam logic [CNT_W-1:0] GUARD_END_C = CNT_W'(2 * TOL_TICKS - 1);

  logic [CNT_W-1:0] cnt;
  logic running;
  logic guard;
  logic synthFire;

  always_comb begin
    synthFire = running && !sofTok && (cnt == LIMIT_C);
    sofEvt    = (sofTok && !guard) || synthFire;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt     <= '0;
      running <= 1'b0;
      guard   <= 1'b0;
    end else if (sofTok) begin
      running <= 1'b1;
      cnt     <= '0;
      guard   <= 1'b0;
    end else if (synthFire) begin
      cnt   <= RELOAD_C;
      guard <= 1'b1;
    end else if (running) begin
      cnt <= cnt + 1'b1;
      if (guard && cnt == GUARD_END_C) guard <= 1'b0;
    end
  end

  // R11
  late_tok_muted_chk: assert property (@(posedge clk) disable iff (!rstN)
    synthFire |=> !sofEvt);

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!running && !sofTok) |=> !synthFire);
endmodule

// File: rtl/usb_evt_ctrl.sv
module usb_evt_ctrl
  import usb_evt_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int REG_ADDR    = 6,
  parameter int FRAME_TICKS = 12000,
  parameter int TOL_TICKS   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sofTok,
  input  logic              busRst,
  input  logic              resumeDet,
  input  logic              suspendDet,
  input  logic              suspEn,
  input  logic              suspended,
  input  logic              rdStb,
  input  logic [ADDR_W-1:0] rdAddr,
  output evtStrb_t          strb
);
  localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(REG_ADDR);

  logic sofEvt;

  usb_frame_timer #(
    .FRAME_TICKS(FRAME_TICKS),
    .TOL_TICKS  (TOL_TICKS)
  ) u_timer (
    .clk   (clk),
    .rstN  (rstN),
    .sofTok(sofTok),
    .sofEvt(sofEvt)
  );

  always_comb begin
    strb.setSof = sofEvt;
    strb.setRst = busRst;
    strb.setRsu = resumeDet && suspended;
    strb.setSus = suspendDet && suspEn;
    strb.clrAll = rdStb && (rdAddr == HIT_ADDR);
  end
endmodule

// File: rtl/usb_evt_dp.sv
module usb_evt_dp
  import usb_evt_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  evtStrb_t          strb,
  output logic [FLAG_W-1:0] flagsQ,
  output logic [DATA_W-1:0] rdData,
  output logic              irq
);
  logic [FLAG_W-1:0] setVec;

  always_comb begin
    setVec          = '0;
    setVec[SOF_BIT] = strb.setSof;
    setVec[RST_BIT] = strb.setRst;
    setVec[RSU_BIT] = strb.setRsu;
    setVec[SUS_BIT] = strb.setSus;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flagsQ <= '0;
    else       flagsQ <= (strb.clrAll ? '0 : flagsQ) | setVec;
  end

  always_comb begin
    rdData = strb.clrAll ? DATA_W'(flagsQ) : '0;
    irq    = |flagsQ;
  end

  // R3
  clr_empties_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrAll && setVec == '0) |=> flagsQ == '0);

  // R4
  keep_on_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrAll && strb.setSus) |=> flagsQ[SUS_BIT]);

  // R12
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> $past(setVec != '0));
endmodule

// File: rtl/usb_evt_flags.sv
module usb_evt_flags
  import usb_evt_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 8,
  parameter int REG_ADDR    = 6,
  parameter int FRAME_TICKS = 12000,
  parameter int TOL_TICKS   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sofTok,
  input  logic              busRst,
  input  logic              resumeDet,
  input  logic              suspendDet,
  input  logic              suspEn,
  input  logic              suspended,
  input  logic              rdStb,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              irq
);
  evtStrb_t          strb;
  logic [FLAG_W-1:0] flagsQ;

  usb_evt_ctrl #(
    .ADDR_W     (ADDR_W),
    .REG_ADDR   (REG_ADDR),
    .FRAME_TICKS(FRAME_TICKS),
    .TOL_TICKS  (TOL_TICKS)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .sofTok    (sofTok),
    .busRst    (busRst),
    .resumeDet (resumeDet),
    .suspendDet(suspendDet),
    .suspEn    (suspEn),
    .suspended (suspended),
    .rdStb     (rdStb),
    .rdAddr    (rdAddr),
    .strb      (strb)
  );

  usb_evt_dp #(
    .DATA_W(DATA_W)
  ) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .strb  (strb),
    .flagsQ(flagsQ),
    .rdData(rdData),
    .irq   (irq)
  );

  // R1
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdData[DATA_W-1:FLAG_W] == '0);

  // R6
  resume_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagsQ[RSU_BIT]) |-> $past(suspended));

  // R7
  suspend_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagsQ[SUS_BIT]) |-> $past(suspEn));
endmodule

// File: tb/usb_evt_flags_tb.sv
module usb_evt_flags_tb;
  localparam int FRAME = 100;
  localparam int TOL   = 4;
  localparam logic [7:0] REG = 8'h06;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sofTok = 1'b0, busRst = 1'b0, resumeDet = 1'b0, suspendDet = 1'b0;
  logic suspEn = 1'b0, suspended = 1'b0, rdStb = 1'b0;
  logic [7:0] rdAddr = 8'h00;
  logic [7:0] rdData;
  logic irq;

  int total = 0;
  int bad = 0;
  logic [7:0] expQ[$];
  string tagQ[$];

  always #4 clk = ~clk;

  usb_evt_flags #(.FRAME_TICKS(FRAME), .TOL_TICKS(TOL)) u_dut (
    .clk(clk), .rstN(rstN), .sofTok(sofTok), .busRst(busRst),
    .resumeDet(resumeDet), .suspendDet(suspendDet), .suspEn(suspEn),
    .suspended(suspended), .rdStb(rdStb), .rdAddr(rdAddr),
    .rdData(rdData), .irq(irq)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops one expected value per read cycle at the register address
  always @(negedge clk) begin
    if (rdStb && rdAddr == REG) begin
      if (expQ.size() == 0) chk("R3 unexpected read", rdData, 8'hxx);
      else chk(tagQ.pop_front(), rdData, expQ.pop_front());
    end
  end

  task automatic doRead(input logic [7:0] exp, input string tag);
    @(posedge clk); #2;
    rdStb = 1'b1; rdAddr = REG;
    expQ.push_back(exp); tagQ.push_back(tag);
    @(posedge clk); #2;
    rdStb = 1'b0;
  endtask

  task automatic pulse(input int which);
    @(posedge clk); #2;
    case (which)
      0: sofTok = 1'b1;
      1: busRst = 1'b1;
      2: resumeDet = 1'b1;
      default: suspendDet = 1'b1;
    endcase
    @(posedge clk); #2;
    sofTok = 1'b0; busRst = 1'b0; resumeDet = 1'b0; suspendDet = 1'b0;
  endtask

  task automatic irqChk(input logic exp, input string tag);
    @(negedge clk);
    chk(tag, {7'd0, irq}, {7'd0, exp});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk); #2;
    rstN = 1'b1;
    irqChk(1'b0, "R2 irq after reset");
    doRead(8'h00, "R2 flags after reset");

    repeat (3 * FRAME) @(posedge clk);
    doRead(8'h00, "R10 no synthetic before first token");

    pulse(1);
    irqChk(1'b1, "R12 irq with flag");
    doRead(8'h04, "R5 bus reset bit2");
    irqChk(1'b0, "R12 irq after clear");
    doRead(8'h00, "R3 cleared after read");

    suspended = 1'b0; pulse(2);
    doRead(8'h00, "R6 resume ignored when awake");
    suspended = 1'b1; pulse(2);
    doRead(8'h02, "R6 resume while suspended");

    suspEn = 1'b0; pulse(3);
    doRead(8'h00, "R7 suspend ignored when disabled");
    suspEn = 1'b1; pulse(3);
    doRead(8'h01, "R7 suspend when enabled");

    // read at another address must not clear and must show zero
    pulse(1);
    @(posedge clk); #2; rdStb = 1'b1; rdAddr = 8'h05;
    @(negedge clk); chk("R1 other address reads zero", rdData, 8'h00);
    @(posedge clk); #2; rdStb = 1'b0;
    doRead(8'h04, "R3 other address did not clear");

    // event coinciding with a clearing read
    pulse(1);
    @(posedge clk); #2;
    rdStb = 1'b1; rdAddr = REG; suspendDet = 1'b1;
    expQ.push_back(8'h04); tagQ.push_back("R4 pre-clear value");
    @(posedge clk); #2;
    rdStb = 1'b0; suspendDet = 1'b0;
    doRead(8'h01, "R4 event kept through clear");

    // all four at once
    @(posedge clk); #2;
    sofTok = 1'b1; busRst = 1'b1; resumeDet = 1'b1; suspendDet = 1'b1;
    @(posedge clk); #2;
    sofTok = 1'b0; busRst = 1'b0; resumeDet = 1'b0; suspendDet = 1'b0;
    doRead(8'h0F, "R1 full bit layout");
    doRead(8'h00, "R3 full clear");

    // the all-at-once token started the timer; restart it from a known token
    pulse(0);
    doRead(8'h08, "R8 token sets bit3");
    repeat (FRAME + TOL - 3) @(posedge clk);
    irqChk(1'b0, "R9 no synthetic before due");
    @(posedge clk);
    irqChk(1'b1, "R9 synthetic at due edge");
    doRead(8'h08, "R9 synthetic sets bit3");
    repeat (FRAME - 3) @(posedge clk);
    irqChk(1'b0, "R9 second synthetic not early");
    @(posedge clk);
    irqChk(1'b1, "R9 second synthetic on time");

    // late token in the same cycle as the clearing read
    @(posedge clk); #2;
    rdStb = 1'b1; rdAddr = REG; sofTok = 1'b1;
    expQ.push_back(8'h08); tagQ.push_back("R11 synthetic flag read");
    @(posedge clk); #2;
    rdStb = 1'b0; sofTok = 1'b0;
    doRead(8'h00, "R11 late token raises no flag");
    repeat (FRAME + TOL - 3) @(posedge clk);
    irqChk(1'b0, "R11 resync not early");
    @(posedge clk);
    irqChk(1'b1, "R11 resync due edge");

    repeat (2) @(posedge clk);
    if (expQ.size() != 0) chk("R3 reads outstanding", 8'(expQ.size()), 8'h00);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule